// File: doc/BRIEF.md
# JEDEC Manufacturer ID Bank Decoder

This block parses the byte stream that a serial flash returns for its read-identification command, taking one byte on each cycle in which a valid strobe is high. Manufacturer codes are banked: every leading byte equal to 0x7F is a continuation code that moves the vendor one bank higher. The first byte that is not 0x7F is the manufacturer code. The two bytes after it form a 16-bit device model, with the first of the two in the upper half.

A start pulse arms the decoder and clears its state. The response has a fixed length (`RESP_LEN`, default 6 bytes). The decoder takes in every byte up to that length, including the padding after the model. It then raises `done` and holds the result until the next start. A stream with more continuation codes than `MAX_CONT` (default 5) is rejected. So is a stream that ends before the model is complete. In both cases `done` and `error` rise together and the result fields read zero.

Top module: `jedec_bank_decoder`

## Requirements
- R1: After reset, `done`, `error`, `bank`, `mfr_id` and `model` are all zero. Bytes strobed before the first `start` pulse are ignored.
- R2: Each 0x7F byte seen before the vendor byte increments the bank. On success, `bank` equals the number of such bytes (for example 7F 7F FE 60 18 00 gives bank 2).
- R3: On success, `mfr_id` is the first byte of the stream that is not 0x7F.
- R4: On success, `model` is {first byte after the vendor, second byte after the vendor}.
- R5: `done` rises, with `error` low, at the clock edge that accepts byte number `RESP_LEN` and not earlier. Bytes between the model and the end of the response do not change the result.
- R6: A 0x7F byte that arrives when `MAX_CONT` continuation codes have already been counted raises `done` and `error` at that edge. `bank`, `mfr_id` and `model` then read zero.
- R7: If byte number `RESP_LEN` is accepted before the model is complete, `done` and `error` rise at that edge. The result fields read zero.
- R8: A `start` pulse clears all outputs and counters at the next edge. A byte strobed in the same cycle as `start` is dropped.
- R9: Once `done` is high, further bytes are ignored, and all outputs hold until the next `start`.
- R10: Cycles with `byte_valid` low consume nothing, so gaps inside a stream do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears state and arms decoding of a new stream |
| byte_valid | input | 1 | Strobe: `byte_data` holds a response byte |
| byte_data | input | BYTE_W (8) | Response byte |
| bank | output | BANK_W (3) | Number of continuation codes before the vendor byte |
| mfr_id | output | BYTE_W (8) | Manufacturer code |
| model | output | 2*BYTE_W (16) | Device model, first byte after the vendor in the upper half |
| done | output | 1 | Decoding finished, successfully or not |
| error | output | 1 | Stream rejected (bank overflow or truncated model) |

## Verification
Two checks can fall on the same byte: the bank-limit check and the end-of-response check. A stream of six 0x7F bytes makes the sixth one both exceed `MAX_CONT` and be the last byte of the response. The scoreboard expects a rejection with zeroed fields, not a success reporting bank 5. A second overlap puts a strobed 0x7F in the cycle of the start pulse. The decode that follows must report bank 0, which shows that the start took priority and the byte was dropped.

// File: rtl/jedec_bank_pkg.sv
package jedec_bank_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREFIX,
    ST_MODEL_HI,
    ST_MODEL_LO,
    ST_PAD,
    ST_FINISHED
  } jbd_state_e;
endpackage

// File: rtl/jbd_cont_counter.sv
module jbd_cont_counter #(
  parameter int MAX_CONT = 5,
  localparam int CNT_W = $clog2(MAX_CONT + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  always_ff @(posedge clk) begin
    if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign at_limit = (count == CNT_W'(MAX_CONT));

  always_ff @(posedge clk) begin
    if (!clr) assert_cont_in_range_R6: assert (count <= CNT_W'(MAX_CONT))
      else $error("continuation count beyond limit");
  end
endmodule

// File: rtl/jbd_byte_index.sv
module jbd_byte_index #(
  parameter int RESP_LEN = 6,
  localparam int IDX_W = (RESP_LEN > 1) ? $clog2(RESP_LEN) : 1
) (
  input  logic clk,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (clr) idx <= '0;
    else if (inc && !last) idx <= idx + 1'b1;
  end

  assign last = (idx == IDX_W'(RESP_LEN - 1));

  always_ff @(posedge clk) begin
    if (!clr) assert_index_in_range_R5: assert (idx < IDX_W'(RESP_LEN))
      else $error("byte index beyond response length");
  end
endmodule

// File: rtl/jbd_fields.sv
module jbd_fields #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              cap_vendor,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] vendor_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      vendor_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      if (cap_vendor) vendor_q <= din;
      if (cap_hi)     hi_q     <= din;
      if (cap_lo)     lo_q     <= din;
    end
  end
endmodule

// File: rtl/jbd_ctrl.sv
module jbd_ctrl
  import jedec_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic byte_valid,
  input  logic is_cont,
  input  logic at_limit,
  input  logic last,
  output logic accept,
  output logic cnt_inc,
  output logic cap_vendor,
  output logic cap_hi,
  output logic cap_lo,
  output logic fin_ok,
  output logic fin_err
);
  jbd_state_e state, state_nx;

  always_comb begin
    state_nx   = state;
    accept     = 1'b0;
    cnt_inc    = 1'b0;
    cap_vendor = 1'b0;
    cap_hi     = 1'b0;
    cap_lo     = 1'b0;
    fin_ok     = 1'b0;
    fin_err    = 1'b0;
    if (byte_valid) begin
      unique case (state)
        ST_PREFIX: begin
          accept = 1'b1;
          if (is_cont) begin
            if (at_limit || last) begin
              fin_err  = 1'b1;
              state_nx = ST_FINISHED;
            end else begin
              cnt_inc = 1'b1;
            end
          end else begin
            cap_vendor = 1'b1;
            if (last) begin
              fin_err  = 1'b1;
              state_nx = ST_FINISHED;
            end else begin
              state_nx = ST_MODEL_HI;
            end
          end
        end
        ST_MODEL_HI: begin
          accept = 1'b1;
          cap_hi = 1'b1;
          if (last) begin
            fin_err  = 1'b1;
            state_nx = ST_FINISHED;
          end else begin
            state_nx = ST_MODEL_LO;
          end
        end
        ST_MODEL_LO: begin
          accept = 1'b1;
          cap_lo = 1'b1;
          if (last) begin
            fin_ok   = 1'b1;
            state_nx = ST_FINISHED;
          end else begin
            state_nx = ST_PAD;
          end
        end
        ST_PAD: begin
          accept = 1'b1;
          if (last) begin
            fin_ok   = 1'b1;
            state_nx = ST_FINISHED;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else if (start) state <= ST_PREFIX;
    else state <= state_nx;
  end

  assert_finish_once_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINISHED && !start) |=> (state == ST_FINISHED))
    else $error("left finished state without start");
endmodule

// File: rtl/jedec_bank_decoder.sv
module jedec_bank_decoder #(
  parameter int BYTE_W    = 8,
  parameter int RESP_LEN  = 6,
  parameter int MAX_CONT  = 5,
  parameter logic [BYTE_W-1:0] CONT_CODE = 8'h7F,
  localparam int BANK_W = $clog2(MAX_CONT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_data,
  output logic [BANK_W-1:0]   bank,
  output logic [BYTE_W-1:0]   mfr_id,
  output logic [2*BYTE_W-1:0] model,
  output logic                done,
  output logic                error
);
  logic clr;
  logic accept, cnt_inc, cap_vendor, cap_hi, cap_lo, fin_ok, fin_err;
  logic at_limit, last;
  logic [BANK_W-1:0] cont_cnt;
  logic [BYTE_W-1:0] vendor_q, hi_q, lo_q;

  assign clr = rst || start;

  jbd_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .byte_valid (byte_valid),
    .is_cont    (byte_data == CONT_CODE),
    .at_limit   (at_limit),
    .last       (last),
    .accept     (accept),
    .cnt_inc    (cnt_inc),
    .cap_vendor (cap_vendor),
    .cap_hi     (cap_hi),
    .cap_lo     (cap_lo),
    .fin_ok     (fin_ok),
    .fin_err    (fin_err)
  );

  jbd_cont_counter #(.MAX_CONT(MAX_CONT)) u_cont (
    .clk      (clk),
    .clr      (clr),
    .inc      (cnt_inc),
    .count    (cont_cnt),
    .at_limit (at_limit)
  );

  jbd_byte_index #(.RESP_LEN(RESP_LEN)) u_index (
    .clk  (clk),
    .clr  (clr),
    .inc  (accept),
    .last (last)
  );

  jbd_fields #(.BYTE_W(BYTE_W)) u_fields (
    .clk        (clk),
    .clr        (clr),
    .cap_vendor (cap_vendor),
    .cap_hi     (cap_hi),
    .cap_lo     (cap_lo),
    .din        (byte_data),
    .vendor_q   (vendor_q),
    .hi_q       (hi_q),
    .lo_q       (lo_q)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      bank   <= '0;
      mfr_id <= '0;
      model  <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else if (fin_ok) begin
      bank   <= cont_cnt;
      mfr_id <= vendor_q;
      model  <= {hi_q, (cap_lo ? byte_data : lo_q)};
      done   <= 1'b1;
      error  <= 1'b0;
    end else if (fin_err) begin
      bank   <= '0;
      mfr_id <= '0;
      model  <= '0;
      done   <= 1'b1;
      error  <= 1'b1;
    end
  end

  assert_error_has_done_R6: assert property (@(posedge clk) disable iff (rst)
    error |-> done) else $error("error without done");

  assert_error_zero_fields_R7: assert property (@(posedge clk) disable iff (rst)
    error |-> (bank == '0 && mfr_id == '0 && model == '0))
    else $error("rejected stream left result fields nonzero");

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !error && bank == '0))
    else $error("start did not clear result");

  assert_hold_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(model) && $stable(mfr_id) && $stable(bank)))
    else $error("result changed after done");
endmodule

// File: tb/jedec_bank_decoder_tb.sv
module jedec_bank_decoder_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        err;
    logic [2:0]  bank;
    logic [7:0]  mfr;
    logic [15:0] model;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic [2:0] bank;
  logic [7:0] mfr_id;
  logic [15:0] model;
  logic done, error;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit prev_done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  jedec_bank_decoder u_dut (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .bank(bank), .mfr_id(mfr_id), .model(model),
    .done(done), .error(error)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: on each rising done, pop the oldest expected result and compare.
  always @(negedge clk) begin
    if (!rst && done && !prev_done) begin
      if (sb.size() == 0) begin
        check("R5 unexpected done", 32'(done), 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " error"}, 32'(error), 32'(e.err));
        check({e.tag, " bank"},  32'(bank),  32'(e.bank));
        check({e.tag, " mfr"},   32'(mfr_id), 32'(e.mfr));
        check({e.tag, " model"}, 32'(model), 32'(e.model));
      end
    end
    prev_done = done;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
    byte_data  = 8'h7F;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic run_stream(input logic [47:0] s, input int gap, input logic e_err,
                            input logic [2:0] e_bank, input logic [7:0] e_mfr,
                            input logic [15:0] e_model, input string tag);
    exp_t e;
    e.err = e_err; e.bank = e_bank; e.mfr = e_mfr; e.model = e_model; e.tag = tag;
    sb.push_back(e);
    pulse_start();
    for (int i = 0; i < 6; i++) put_byte(s[47-8*i -: 8], gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 done after reset", 32'(done), 0);
    check("R1 error after reset", 32'(error), 0);
    check("R1 fields after reset", {8'(bank), mfr_id, model} == 0 ? 32'h0 : 32'h1, 0);
    // R1: bytes before any start are ignored
    for (int i = 0; i < 6; i++) put_byte(8'h11, 0);
    check("R1 bytes before start", 32'(done), 0);

    // R3 R4 R5: bank 0 vendor
    run_stream(48'hFE_60_18_00_00_00, 0, 0, 3'd0, 8'hFE, 16'h6018, "R3 R4 bank0");
    // R2: two continuation codes
    run_stream(48'h7F_7F_FE_60_18_00, 0, 0, 3'd2, 8'hFE, 16'h6018, "R2 bank2");
    // R10: gaps between strobes
    run_stream(48'h7F_C2_20_16_00_00, 3, 0, 3'd1, 8'hC2, 16'h2016, "R10 gaps");
    // R5: padding bytes of any value have no effect
    run_stream(48'h01_AA_BB_FF_7F_7F, 0, 0, 3'd0, 8'h01, 16'hAABB, "R5 padding");
    // R2 R4: three continuation codes, model ends on last byte
    run_stream(48'h7F_7F_7F_9D_12_34, 0, 0, 3'd3, 8'h9D, 16'h1234, "R2 bank3");

    // R5: done not raised before the last byte
    begin
      exp_t e;
      e.err = 0; e.bank = 0; e.mfr = 8'h20; e.model = 16'hBA19; e.tag = "R5 timing";
      sb.push_back(e);
      pulse_start();
      put_byte(8'h20, 0); put_byte(8'hBA, 0); put_byte(8'h19, 0);
      put_byte(8'h00, 0); put_byte(8'h00, 0);
      check("R5 done before last byte", 32'(done), 0);
      put_byte(8'h00, 0);
      check("R5 done at last byte", 32'(done), 1);
    end

    // R9: bytes after done ignored, outputs hold
    put_byte(8'h7F, 0); put_byte(8'h55, 0); put_byte(8'h66, 0);
    check("R9 done held", 32'(done), 1);
    check("R9 model held", 32'(model), 32'hBA19);
    check("R9 mfr held", 32'(mfr_id), 32'h20);

    // R7: model truncated by response length
    run_stream(48'h7F_7F_7F_7F_EF_40, 0, 1, 3'd0, 8'h00, 16'h0000, "R7 truncated");
    // R6: six continuation codes: limit exceeded on the final byte
    run_stream(48'h7F_7F_7F_7F_7F_7F, 0, 1, 3'd0, 8'h00, 16'h0000, "R6 overflow");

    // R8: start clears, and a byte strobed with start is dropped
    @(negedge clk);
    start = 1'b1; byte_valid = 1'b1; byte_data = 8'h7F;
    @(negedge clk);
    start = 1'b0; byte_valid = 1'b0;
    check("R8 done cleared", 32'(done), 0);
    check("R8 error cleared", 32'(error), 0);
    begin
      exp_t e;
      e.err = 0; e.bank = 0; e.mfr = 8'hEF; e.model = 16'h4018; e.tag = "R8 dropped byte";
      sb.push_back(e);
      put_byte(8'hEF, 0); put_byte(8'h40, 0); put_byte(8'h18, 0);
      put_byte(8'h00, 0); put_byte(8'h00, 0); put_byte(8'h00, 0);
    end

    repeat (3) @(negedge clk);
    check("R5 all expected results seen", 32'(sb.size()), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule